// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This block holds the machine-level control and status registers of a single 32-bit hart and decides when the hart leaves its instruction stream for a trap handler. The pipeline decodes each instruction and presents it with a valid strobe, its PC, and flags for CSR access, environment call, trap return and decode-illegal. The unit then does one of the following for that instruction, on the next clock edge. It executes the CSR read-modify-write. It takes an exception or a timer interrupt, saving state and steering the fetch stage to the handler. Or it performs the trap return.

CSR accesses use a 12-bit register number that is separate from memory. An access returns the old register value and, in the same step, replaces it, ORs bits into it or clears bits from it. Only machine and user privilege exist. Trap vectoring is direct only. The redirect target and the read data are combinational from the presented instruction and the current register state, so the pipeline can use them in the same cycle.

Top module: `mtrap_csr_unit`

## Requirements
- R1: `csr_rdata` shows the addressed CSR's value before the access; op code 01 replaces it with the source, and does so even when the source index is zero.
- R2: Op code 10 ORs the source into the CSR and op code 11 clears the source's one bits. With a source index of zero, neither op writes: a read-only CSR can then be read without a trap.
- R3: With `csr_imm` high, the source is the 5-bit `csr_src_idx` zero-extended to 32 bits instead of `csr_src_data`.
- R4: Any of the following raises an illegal-instruction exception (cause code 2) and leaves every CSR except the trap state unchanged: a CSR number that is not implemented, a write to a read-only number (bits 11:10 equal to 11), or any CSR access from user mode. The implemented numbers are 0x300 status, 0x304 enable, 0x305 vector base, 0x341 exception PC, 0x342 cause, 0x344 pending, and 0xF14 hart ID.
- R5: On trap entry, status bit 7 takes the old bit 3 and bit 3 clears. Bits 12:11 take the privilege the hart had before the trap, and the hart enters machine mode (`priv_mode` 11).
- R6: The cause register's bit 31 is 1 for an interrupt and 0 for an exception, with the code in bits 4:0. The codes are: 2 for an illegal instruction, 8 for an environment call from user mode, 11 for an environment call from machine mode, and 7 for the timer interrupt.
- R7: The exception PC register receives the PC of the trapping instruction (for an environment call, that instruction itself), or of the instruction displaced by an interrupt. Its bits 1:0 always read zero.
- R8: On a trap, `redirect_valid` is high in the same cycle and `redirect_pc` is the vector base with bits 1:0 forced to zero. The vector base reads with bits 1:0 equal to zero.
- R9: A timer interrupt is taken on a valid instruction only when status bit 3, enable bit 7 and `timer_irq` are all 1. That instruction then has no other effect.
- R10: When an exception and an enabled interrupt coincide, the exception is taken.
- R11: A trap return in machine mode redirects to the exception PC and sets the following: bit 3 takes bit 7, bit 7 becomes 1, bits 12:11 become 00, and the privilege becomes the old bits 12:11. A trap return in user mode is an illegal instruction.
- R12: Bit 7 of the pending CSR follows `timer_irq`, and writes to the pending CSR have no effect.
- R13: After reset the hart is in machine mode, the status, enable, exception PC and cause registers read 0, and the vector base reads `RESET_TVEC` with bits 1:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_pc | input | 32 | PC of the presented instruction |
| csr_en | input | 1 | Instruction is a CSR access |
| csr_op | input | 2 | 01 replace, 10 set bits, 11 clear bits |
| csr_imm | input | 1 | Immediate source form |
| csr_addr | input | 12 | CSR number |
| csr_src_idx | input | 5 | Source register index, or the immediate |
| csr_src_data | input | 32 | Source register value |
| is_ecall | input | 1 | Instruction is an environment call |
| is_mret | input | 1 | Instruction is a trap return |
| is_illegal | input | 1 | Decoder found the instruction illegal |
| timer_irq | input | 1 | Machine timer interrupt request level |
| csr_rdata | output | 32 | Old value of the addressed CSR |
| redirect_valid | output | 1 | Fetch must continue at redirect_pc |
| redirect_pc | output | 32 | Handler or return address |
| priv_mode | output | 2 | Current privilege, 11 machine, 00 user |

## Verification
`csr_rdata`, `redirect_valid` and `redirect_pc` depend on the presented instruction within the same cycle. The bench therefore samples them shortly after driving inputs on the falling edge, before the rising edge that commits the instruction. Register updates and `priv_mode` change on that rising edge, one cycle after the stimulus. They are checked only afterwards, by reading back through zero-source set accesses or by sampling `priv_mode` on the next falling edge. Interrupt gating and ordering are judged from the cause value and the exception PC read back after the redirect.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
    localparam int XLEN    = 32;
    localparam int CAUSE_W = 5;
    localparam int ADDR_W  = 12;

    localparam logic [1:0] PRIV_M = 2'b11;
    localparam logic [1:0] PRIV_U = 2'b00;

    localparam logic [1:0] OP_RW = 2'b01;
    localparam logic [1:0] OP_RS = 2'b10;
    localparam logic [1:0] OP_RC = 2'b11;

    localparam logic [ADDR_W-1:0] A_STATUS = 12'h300;
    localparam logic [ADDR_W-1:0] A_ENABLE = 12'h304;
    localparam logic [ADDR_W-1:0] A_TVEC   = 12'h305;
    localparam logic [ADDR_W-1:0] A_EPC    = 12'h341;
    localparam logic [ADDR_W-1:0] A_CAUSE  = 12'h342;
    localparam logic [ADDR_W-1:0] A_PEND   = 12'h344;
    localparam logic [ADDR_W-1:0] A_HARTID = 12'hF14;

    localparam logic [CAUSE_W-1:0] C_ILLEGAL = 5'd2;
    localparam logic [CAUSE_W-1:0] C_ECALL_U = 5'd8;
    localparam logic [CAUSE_W-1:0] C_ECALL_M = 5'd11;
    localparam logic [CAUSE_W-1:0] C_TIMER   = 5'd7;

    localparam int B_IE   = 3;
    localparam int B_PIE  = 7;
    localparam int B_PP   = 11;
    localparam int B_TMR  = 7;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_STATUS, SEL_ENABLE, SEL_TVEC,
        SEL_EPC, SEL_CAUSE, SEL_PEND, SEL_HARTID
    } csr_sel_e;

    typedef struct packed {
        logic [1:0]         priv;
        logic               ie;
        logic               pie;
        logic [1:0]         pp;
        logic               tmr_en;
        logic [XLEN-3:0]    tvec;
        logic [XLEN-3:0]    epc;
        logic               c_irq;
        logic [CAUSE_W-1:0] c_code;
    } mtc_state_t;
endpackage

// File: rtl/mtc_csr_decode.sv
module mtc_csr_decode
    import mtc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        priv,
    input  logic              writes,
    output csr_sel_e          sel,
    output logic              fault
);
    always_comb begin
        case (addr)
            A_STATUS: sel = SEL_STATUS;
            A_ENABLE: sel = SEL_ENABLE;
            A_TVEC:   sel = SEL_TVEC;
            A_EPC:    sel = SEL_EPC;
            A_CAUSE:  sel = SEL_CAUSE;
            A_PEND:   sel = SEL_PEND;
            A_HARTID: sel = SEL_HARTID;
            default:  sel = SEL_NONE;
        endcase
        fault = (sel == SEL_NONE)
              || ((addr[9:8] == 2'b11) && (priv != PRIV_M))
              || ((addr[11:10] == 2'b11) && writes);
    end
endmodule

// File: rtl/mtc_trap_arbiter.sv
module mtc_trap_arbiter
    import mtc_pkg::*;
(
    input  logic               valid,
    input  logic               illegal,
    input  logic               ecall,
    input  logic [1:0]         priv,
    input  logic               irq_ready,
    output logic               take,
    output logic               is_irq,
    output logic               exc,
    output logic [CAUSE_W-1:0] code
);
    always_comb begin
        exc    = valid && (illegal || ecall);
        is_irq = valid && irq_ready && !exc;
        take   = exc || is_irq;
        if (illegal)
            code = C_ILLEGAL;
        else if (ecall)
            code = (priv == PRIV_M) ? C_ECALL_M : C_ECALL_U;
        else
            code = C_TIMER;
    end
endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit
    import mtc_pkg::*;
#(
    parameter logic [31:0] HART_ID    = 32'd0,
    parameter logic [31:0] RESET_TVEC = 32'h0000_0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        instr_valid,
    input  logic [31:0] instr_pc,
    input  logic        csr_en,
    input  logic [1:0]  csr_op,
    input  logic        csr_imm,
    input  logic [11:0] csr_addr,
    input  logic [4:0]  csr_src_idx,
    input  logic [31:0] csr_src_data,
    input  logic        is_ecall,
    input  logic        is_mret,
    input  logic        is_illegal,
    input  logic        timer_irq,
    output logic [31:0] csr_rdata,
    output logic        redirect_valid,
    output logic [31:0] redirect_pc,
    output logic [1:0]  priv_mode
);
    mtc_state_t st_q, st_d;

    logic               src_zero, writes, csr_fault, illegal_any;
    logic               trap_take, trap_irq, exc_any, mret_do;
    logic [CAUSE_W-1:0] trap_code;
    logic [XLEN-1:0]    src, old_v, new_v;
    csr_sel_e           sel;

    assign src_zero = (csr_src_idx == 5'd0);
    assign writes   = (csr_op == OP_RW) || ((csr_op != 2'b00) && !src_zero);

    mtc_csr_decode u_dec (
        .addr   (csr_addr),
        .priv   (st_q.priv),
        .writes (writes),
        .sel    (sel),
        .fault  (csr_fault)
    );

    assign illegal_any = is_illegal || (csr_en && csr_fault)
                       || (is_mret && (st_q.priv != PRIV_M));

    mtc_trap_arbiter u_arb (
        .valid     (instr_valid),
        .illegal   (illegal_any),
        .ecall     (is_ecall),
        .priv      (st_q.priv),
        .irq_ready (st_q.ie && st_q.tmr_en && timer_irq),
        .take      (trap_take),
        .is_irq    (trap_irq),
        .exc       (exc_any),
        .code      (trap_code)
    );

    assign mret_do = instr_valid && is_mret && !trap_take;

    always_comb begin
        old_v = '0;
        case (sel)
            SEL_STATUS: begin
                old_v[B_IE]          = st_q.ie;
                old_v[B_PIE]         = st_q.pie;
                old_v[B_PP+1:B_PP]   = st_q.pp;
            end
            SEL_ENABLE: old_v[B_TMR] = st_q.tmr_en;
            SEL_TVEC:   old_v = {st_q.tvec, 2'b00};
            SEL_EPC:    old_v = {st_q.epc, 2'b00};
            SEL_CAUSE: begin
                old_v[XLEN-1]      = st_q.c_irq;
                old_v[CAUSE_W-1:0] = st_q.c_code;
            end
            SEL_PEND:   old_v[B_TMR] = timer_irq;
            SEL_HARTID: old_v = HART_ID;
            default:    old_v = '0;
        endcase

        src = csr_imm ? {{(XLEN-5){1'b0}}, csr_src_idx} : csr_src_data;
        case (csr_op)
            OP_RW:   new_v = src;
            OP_RS:   new_v = old_v | src;
            OP_RC:   new_v = old_v & ~src;
            default: new_v = old_v;
        endcase
    end

    always_comb begin
        st_d           = st_q;
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        if (trap_take) begin
            st_d.epc       = instr_pc[XLEN-1:2];
            st_d.c_irq     = trap_irq;
            st_d.c_code    = trap_code;
            st_d.pie       = st_q.ie;
            st_d.ie        = 1'b0;
            st_d.pp        = st_q.priv;
            st_d.priv      = PRIV_M;
            redirect_valid = 1'b1;
            redirect_pc    = {st_q.tvec, 2'b00};
        end else if (mret_do) begin
            st_d.ie        = st_q.pie;
            st_d.pie       = 1'b1;
            st_d.pp        = PRIV_U;
            st_d.priv      = st_q.pp;
            redirect_valid = 1'b1;
            redirect_pc    = {st_q.epc, 2'b00};
        end else if (instr_valid && csr_en && writes) begin
            case (sel)
                SEL_STATUS: begin
                    st_d.ie  = new_v[B_IE];
                    st_d.pie = new_v[B_PIE];
                    st_d.pp  = (new_v[B_PP+1:B_PP] == PRIV_M) ? PRIV_M : PRIV_U;
                end
                SEL_ENABLE: st_d.tmr_en = new_v[B_TMR];
                SEL_TVEC:   st_d.tvec   = new_v[XLEN-1:2];
                SEL_EPC:    st_d.epc    = new_v[XLEN-1:2];
                SEL_CAUSE: begin
                    st_d.c_irq  = new_v[XLEN-1];
                    st_d.c_code = new_v[CAUSE_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.priv <= PRIV_M;
            st_q.tvec <= RESET_TVEC[XLEN-1:2];
        end else begin
            st_q <= st_d;
        end
    end

    assign csr_rdata = old_v;
    assign priv_mode = st_q.priv;
endmodule

// File: rtl/mtc_checker.sv
module mtc_checker
    import mtc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        timer_irq,
    input logic        redirect_valid,
    input logic [31:0] redirect_pc,
    input logic        trap_take,
    input logic        trap_irq,
    input logic        exc_any,
    input logic        mret_do,
    input mtc_state_t  st_q
);
    assert_vec_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (redirect_pc[1:0] == 2'b00));

    assert_entry_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (!st_q.ie && st_q.priv == PRIV_M
                       && st_q.pie == $past(st_q.ie) && st_q.pp == $past(st_q.priv)));

    assert_cause_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (st_q.c_irq == $past(trap_irq)));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_irq |-> (st_q.ie && st_q.tmr_en && timer_irq));

    assert_exc_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_irq |-> !exc_any);

    assert_mret_restore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mret_do |=> (st_q.pie && st_q.pp == PRIV_U
                     && st_q.ie == $past(st_q.pie) && st_q.priv == $past(st_q.pp)));
endmodule

bind mtrap_csr_unit mtc_checker u_mtc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .timer_irq      (timer_irq),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .trap_take      (trap_take),
    .trap_irq       (trap_irq),
    .exc_any        (exc_any),
    .mret_do        (mret_do),
    .st_q           (st_q)
);

// File: tb/tb_mtrap_csr_unit.sv
module tb_mtrap_csr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_pc = '0;
    logic        csr_en = 1'b0;
    logic [1:0]  csr_op = 2'b00;
    logic        csr_imm = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [4:0]  csr_src_idx = '0;
    logic [31:0] csr_src_data = '0;
    logic        is_ecall = 1'b0;
    logic        is_mret = 1'b0;
    logic        is_illegal = 1'b0;
    logic        timer_irq = 1'b0;
    logic [31:0] csr_rdata;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic [1:0]  priv_mode;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] s_rdata, s_rpc, rv;
    logic        s_rv;

    always #5 clk = ~clk;

    mtrap_csr_unit #(.HART_ID(32'd3), .RESET_TVEC(32'h0000_0103)) dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_pc(instr_pc),
        .csr_en(csr_en), .csr_op(csr_op), .csr_imm(csr_imm), .csr_addr(csr_addr),
        .csr_src_idx(csr_src_idx), .csr_src_data(csr_src_data), .is_ecall(is_ecall),
        .is_mret(is_mret), .is_illegal(is_illegal), .timer_irq(timer_irq),
        .csr_rdata(csr_rdata), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .priv_mode(priv_mode)
    );

    // {op, imm, addr, idx, data, expected old value}
    localparam int NV = 22;
    localparam logic [83:0] VEC [NV] = '{
        {2'b01, 1'b0, 12'h305, 5'd1,  32'h0000_1003, 32'h0000_0100},
        {2'b10, 1'b0, 12'h305, 5'd0,  32'h0000_FFFF, 32'h0000_1000},
        {2'b10, 1'b0, 12'h305, 5'd0,  32'h0000_0000, 32'h0000_1000},
        {2'b10, 1'b1, 12'h305, 5'd4,  32'hFFFF_FFFF, 32'h0000_1000},
        {2'b11, 1'b1, 12'h305, 5'd4,  32'h0000_0000, 32'h0000_1004},
        {2'b01, 1'b0, 12'h304, 5'd1,  32'hFFFF_FFFF, 32'h0000_0000},
        {2'b10, 1'b0, 12'h304, 5'd0,  32'h0000_0000, 32'h0000_0080},
        {2'b11, 1'b0, 12'h304, 5'd3,  32'h0000_0080, 32'h0000_0080},
        {2'b10, 1'b0, 12'h304, 5'd0,  32'h0000_0000, 32'h0000_0000},
        {2'b10, 1'b0, 12'h300, 5'd1,  32'h0000_1888, 32'h0000_0000},
        {2'b10, 1'b0, 12'h300, 5'd0,  32'h0000_0000, 32'h0000_1888},
        {2'b01, 1'b0, 12'h300, 5'd2,  32'h0000_0808, 32'h0000_1888},
        {2'b10, 1'b0, 12'h300, 5'd0,  32'h0000_0000, 32'h0000_0008},
        {2'b10, 1'b0, 12'hF14, 5'd0,  32'h0000_0000, 32'h0000_0003},
        {2'b01, 1'b0, 12'h341, 5'd1,  32'h0000_1237, 32'h0000_0000},
        {2'b10, 1'b0, 12'h341, 5'd0,  32'h0000_0000, 32'h0000_1234},
        {2'b01, 1'b0, 12'h342, 5'd1,  32'hFFFF_FFEB, 32'h0000_0000},
        {2'b10, 1'b0, 12'h342, 5'd0,  32'h0000_0000, 32'h8000_000B},
        {2'b01, 1'b0, 12'h344, 5'd1,  32'hFFFF_FFFF, 32'h0000_0000},
        {2'b10, 1'b0, 12'h344, 5'd0,  32'h0000_0000, 32'h0000_0000},
        {2'b01, 1'b1, 12'h341, 5'd31, 32'h0000_0000, 32'h0000_1234},
        {2'b10, 1'b0, 12'h341, 5'd0,  32'h0000_0000, 32'h0000_001C}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // inputs were set at a falling edge; sample, commit on the rising edge, clear
    task automatic step();
        #2;
        s_rdata = csr_rdata;
        s_rv    = redirect_valid;
        s_rpc   = redirect_pc;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0; csr_en = 1'b0; csr_op = 2'b00; csr_imm = 1'b0;
        csr_addr = '0; csr_src_idx = '0; csr_src_data = '0;
        is_ecall = 1'b0; is_mret = 1'b0; is_illegal = 1'b0;
    endtask

    task automatic csr(input logic [1:0] op, input logic imm, input logic [11:0] a,
                       input logic [4:0] idx, input logic [31:0] d, input logic [31:0] pc);
        instr_valid = 1'b1; instr_pc = pc; csr_en = 1'b1; csr_op = op; csr_imm = imm;
        csr_addr = a; csr_src_idx = idx; csr_src_data = d;
        step();
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        csr(2'b10, 1'b0, a, 5'd0, 32'hFFFF_FFFF, 32'h0000_0F00);
        v = s_rdata;
    endtask

    task automatic ecall(input logic [31:0] pc);
        instr_valid = 1'b1; instr_pc = pc; is_ecall = 1'b1; step();
    endtask

    task automatic mret(input logic [31:0] pc);
        instr_valid = 1'b1; instr_pc = pc; is_mret = 1'b1; step();
    endtask

    task automatic nop(input logic [31:0] pc);
        instr_valid = 1'b1; instr_pc = pc; step();
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13 priv", {30'd0, priv_mode}, 32'h3);
        rd(12'h300, rv); check("R13 status", rv, 32'h0);
        rd(12'h342, rv); check("R13 cause", rv, 32'h0);
        rd(12'h304, rv); check("R13 enable", rv, 32'h0);

        // R1 R2 R3 R12 vector table
        for (int i = 0; i < NV; i++) begin
            csr(VEC[i][83:82], VEC[i][81], VEC[i][80:69], VEC[i][68:64],
                VEC[i][63:32], 32'h0000_0800 + 32'(i*4));
            check($sformatf("R1/R2/R3 vec %0d", i), s_rdata, VEC[i][31:0]);
        end

        // R5 R6 R7 R8: ecall from machine mode
        ecall(32'h2000);
        check("R8 redirect valid", {31'd0, s_rv}, 32'h1);
        check("R8 redirect pc", s_rpc, 32'h1000);
        rd(12'h342, rv); check("R6 ecall M cause", rv, 32'd11);
        rd(12'h341, rv); check("R7 epc is ecall", rv, 32'h2000);
        rd(12'h300, rv); check("R5 status after trap", rv, 32'h1880);

        // R11 return to machine
        mret(32'h2004);
        check("R11 mret target", s_rpc, 32'h2000);
        rd(12'h300, rv); check("R11 status after mret", rv, 32'h0088);
        check("R11 priv stays M", {30'd0, priv_mode}, 32'h3);

        // R4: drop to user, then touch a CSR
        csr(2'b01, 1'b0, 12'h341, 5'd1, 32'h3000, 32'h2008);
        mret(32'h200C);
        check("R11 priv to U", {30'd0, priv_mode}, 32'h0);
        csr(2'b10, 1'b0, 12'h300, 5'd0, 32'h0, 32'h3000);
        check("R4 U access redirect", s_rpc, 32'h1000);
        check("R5 priv M after trap", {30'd0, priv_mode}, 32'h3);
        rd(12'h342, rv); check("R4 cause illegal", rv, 32'd2);
        rd(12'h300, rv); check("R5 status pp=U", rv, 32'h0080);

        // R6: ecall from user
        mret(32'h2010);
        ecall(32'h3004);
        rd(12'h342, rv); check("R6 ecall U cause", rv, 32'd8);
        rd(12'h341, rv); check("R7 epc user ecall", rv, 32'h3004);

        // R11: mret in user mode is illegal
        mret(32'h2014);
        mret(32'h3008);
        check("R11 U mret traps", s_rpc, 32'h1000);
        rd(12'h342, rv); check("R11 U mret cause", rv, 32'd2);
        rd(12'h341, rv); check("R11 U mret epc", rv, 32'h3008);

        // R4: unimplemented and read-only writes
        csr(2'b01, 1'b0, 12'h7C0, 5'd1, 32'h1, 32'h5000);
        check("R4 unimpl redirect", {31'd0, s_rv}, 32'h1);
        rd(12'h341, rv); check("R4 unimpl epc", rv, 32'h5000);
        csr(2'b01, 1'b0, 12'hF14, 5'd1, 32'h5, 32'h5004);
        check("R4 ro write redirect", {31'd0, s_rv}, 32'h1);
        rd(12'hF14, rv); check("R4 hartid kept", rv, 32'h3);

        // R9: timer interrupt
        csr(2'b01, 1'b0, 12'h304, 5'd1, 32'h80, 32'h5008);
        csr(2'b10, 1'b1, 12'h300, 5'd8, 32'h0, 32'h500C);
        timer_irq = 1'b1;
        csr(2'b01, 1'b0, 12'h305, 5'd1, 32'h5000, 32'h6000);
        check("R9 irq redirect", s_rpc, 32'h1000);
        rd(12'h342, rv); check("R6 irq cause", rv, 32'h8000_0007);
        rd(12'h341, rv); check("R7 irq epc", rv, 32'h6000);
        rd(12'h305, rv); check("R9 suppressed write", rv, 32'h1000);
        rd(12'h344, rv); check("R12 pending follows", rv, 32'h80);
        nop(32'h6004);
        check("R9 gated by IE", {31'd0, s_rv}, 32'h0);
        csr(2'b11, 1'b0, 12'h304, 5'd1, 32'h80, 32'h6008);
        csr(2'b10, 1'b1, 12'h300, 5'd8, 32'h0, 32'h600C);
        nop(32'h6010);
        check("R9 gated by enable", {31'd0, s_rv}, 32'h0);

        // R10: exception wins over pending interrupt
        csr(2'b10, 1'b0, 12'h304, 5'd1, 32'h80, 32'h6014);
        ecall(32'h7000);
        timer_irq = 1'b0;
        rd(12'h342, rv); check("R10 exception first", rv, 32'd11);
        rd(12'h341, rv); check("R10 epc", rv, 32'h7000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule